// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block turns four external interrupt pins into prioritised requests for a CPU core. Pins 0 and 1 take edge or level detection, sampled straight off the pin with no filter, so a pulse lasting a single cycle is enough. Either of these two pins can also drive a wake request that brings the core out of its hold state. Pins 2 and 3 take edge detection only, on rising, falling or both edges. Each edge they detect also leaves as a one-cycle strobe that a timer can count.

Pin 3 first passes through a digital noise filter. The filter samples the pin at a selectable rate and accepts a new level only after two consecutive samples agree. This sets a minimum pulse width that depends on the rate. A detected edge sets a pending flag, which stays set until software clears it. A level-mode request simply follows the pin. The enabled requests are encoded into one vector address, and the lowest-numbered pin wins.

Top module: `extint_unit`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, with all pins low, `req_o`, `irq_o`, `vec_o`, `tmr_evt_o` and `wake_o` are all zero.
- R2: For pins 0 and 1, mode code 0 detects a rising edge and code 1 detects a falling edge. The pending bit in `req_o` is set in the cycle after the edge and holds until the matching `clr_i` bit is high at a clock edge. The opposite edge has no effect, and so does a change of mode while the pin is steady.
- R3: For pins 0 and 1, mode code 2 makes the request equal to the pin level and code 3 makes it equal to the inverted level. Nothing is latched, so the request drops as soon as the pin leaves the active level, and `clr_i` has no effect on it.
- R4: For pins 2 and 3, mode code 0 detects rising edges, code 1 detects falling edges, and codes 2 and 3 detect both edges. Each detected edge sets a pending bit that holds until cleared.
- R5: `vec_o` is 8'h03, 8'h0B, 8'h13 or 8'h1B for pin 0, 1, 2 or 3. When several enabled requests are active, the lowest-numbered one wins. With no enabled request, `irq_o` is 0 and `vec_o` is 8'h00.
- R6: A low `en_i` bit removes that pin from `irq_o`, `vec_o` and `wake_o`. The pin's pending state stays visible on `req_o`.
- R7: The filter rate code `flt_rate_i` selects sampling on every cycle (0), every 16 cycles (1), or every 64 cycles (2 or 3). At rate 0, a pulse on pin 3 lasting 1 cycle is rejected and a pulse lasting 2 cycles is accepted. An accepted rising edge shows on `req_o` three cycles after the pin rises.
- R8: At rate 1, a pulse on pin 3 lasting 16 cycles is rejected and one lasting 32 cycles is accepted. At rate 2, a pulse lasting 64 cycles is rejected and one lasting 128 cycles is accepted.
- R9: `tmr_evt_o[0]` for pin 2 and `tmr_evt_o[1]` for pin 3 pulse high for exactly one cycle, in the same cycle the pending bit is set. This happens whatever the value of `en_i`.
- R10: `wake_o` is high whenever an enabled request from pin 0 or pin 1 is active.
- R11: When an edge is detected in the same cycle that `clr_i` is high for that pin, the pending bit ends up set.
- R12: A pulse on pin 0 lasting one cycle is detected in rising mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | External interrupt pins 0 to 3 |
| lvl_mode_i | input | 4 | Two-bit mode for pin 0 (bits 1:0) and pin 1 (bits 3:2) |
| edge_mode_i | input | 4 | Two-bit mode for pin 2 (bits 1:0) and pin 3 (bits 3:2) |
| flt_rate_i | input | 2 | Noise filter sampling rate code for pin 3 |
| en_i | input | 4 | Per-pin request enable |
| clr_i | input | 4 | Per-pin pending clear |
| req_o | output | 4 | Raw per-pin request (pending flag or level) |
| irq_o | output | 1 | Any enabled request active |
| vec_o | output | 8 | Vector address of the winning request |
| tmr_evt_o | output | 2 | Timer event strobes from pins 2 and 3 |
| wake_o | output | 1 | Wake request from pins 0 and 1 |

## Verification
The bench builds the block with its default parameters: filter dividers of 16 and 64, vector base 8'h03 and vector step 8. These values keep the 128-cycle acceptance window of the slowest rate short enough that both sides of each pulse-width threshold can be tested within a few hundred cycles. The default vector values also let every address and every priority pairing be checked against the literal codes in R5.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int N_INT = 4;

    typedef enum logic [1:0] {
        LM_RISE = 2'd0,
        LM_FALL = 2'd1,
        LM_HIGH = 2'd2,
        LM_LOW  = 2'd3
    } lvl_mode_e;

    typedef enum logic [1:0] {
        EM_RISE     = 2'd0,
        EM_FALL     = 2'd1,
        EM_BOTH     = 2'd2,
        EM_BOTH_ALT = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        FR_EVERY    = 2'd0,
        FR_MID      = 2'd1,
        FR_SLOW     = 2'd2,
        FR_SLOW_ALT = 2'd3
    } flt_rate_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_s;

    function automatic edge_s edge_of(logic cur, logic prev);
        edge_s e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic [7:0] vec_addr(logic [7:0] base, logic [7:0] step, int unsigned idx);
        return base + step * 8'(idx);
    endfunction

endpackage

// File: rtl/extint_lvl_det.sv
module extint_lvl_det
    import extint_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  lvl_mode_e mode_i,
    input  logic      clr_i,
    output logic      req_o
);

    logic  prev_q;
    logic  pend_q;
    edge_s ed;
    logic  hit;
    logic  lvl_on;
    logic  lvl_req;

    always_comb begin
        ed      = edge_of(pin_i, prev_q);
        hit     = 1'b0;
        lvl_on  = 1'b0;
        lvl_req = 1'b0;
        case (mode_i)
            LM_RISE: hit = ed.rise;
            LM_FALL: hit = ed.fall;
            LM_HIGH: begin
                lvl_on  = 1'b1;
                lvl_req = pin_i;
            end
            default: begin
                lvl_on  = 1'b1;
                lvl_req = ~pin_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= pin_i;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin_i;
            if (hit)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign req_o = lvl_on ? lvl_req : pend_q;

    a_r2_pend_held: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> pend_q);

    a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_i) |=> pend_q);

    a_r3_high_level_drop: assert property (@(posedge clk) disable iff (rst)
        (mode_i == LM_HIGH && !pin_i) |-> !req_o);

endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_i,
    input  edge_mode_e mode_i,
    input  logic       clr_i,
    output logic       req_o,
    output logic       evt_o
);

    logic  prev_q;
    logic  pend_q;
    logic  evt_q;
    edge_s ed;
    logic  hit;

    always_comb begin
        ed = edge_of(lvl_i, prev_q);
        case (mode_i)
            EM_RISE: hit = ed.rise;
            EM_FALL: hit = ed.fall;
            default: hit = ed.rise | ed.fall;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= lvl_i;
            pend_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            evt_q  <= hit;
            if (hit)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign req_o = pend_q;
    assign evt_o = evt_q;

    a_r9_strobe_with_pend: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> req_o);

    a_r4_pend_held: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> pend_q);

    a_r11_edge_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_i) |=> req_o);

endmodule

// File: rtl/extint_filter.sv
module extint_filter
    import extint_pkg::*;
#(
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  flt_rate_e rate_i,
    output logic      lvl_o
);

    localparam int CW = $clog2(DIV_SLOW);
    localparam int MW = $clog2(DIV_MID);

    logic [CW-1:0] cnt_q;
    logic          tick;
    logic          samp_q;
    logic          filt_q;

    always_comb begin
        case (rate_i)
            FR_EVERY: tick = 1'b1;
            FR_MID:   tick = (cnt_q[MW-1:0] == '0);
            default:  tick = (cnt_q == '0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            samp_q <= pin_i;
            filt_q <= pin_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (tick) begin
                samp_q <= pin_i;
                if (pin_i == samp_q)
                    filt_q <= pin_i;
            end
        end
    end

    assign lvl_o = filt_q;

    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(filt_q));

    a_r7_two_samples: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> (filt_q == $past(samp_q)));

endmodule

// File: rtl/extint_prio.sv
module extint_prio
    import extint_pkg::*;
#(
    parameter int         N        = 4,
    parameter logic [7:0] VEC_BASE = 8'h03,
    parameter logic [7:0] VEC_STEP = 8'h08
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] act_i,
    output logic         irq_o,
    output logic [7:0]   vec_o
);

    always_comb begin
        irq_o = 1'b0;
        vec_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                irq_o = 1'b1;
                vec_o = vec_addr(VEC_BASE, VEC_STEP, i);
            end
        end
    end

    a_r5_first_wins: assert property (@(posedge clk) disable iff (rst)
        act_i[0] |-> (vec_o == VEC_BASE));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(|act_i) |-> (vec_o == 8'h00 && !irq_o));

endmodule

// File: rtl/extint_unit.sv
module extint_unit
    import extint_pkg::*;
#(
    parameter int         DIV_MID  = 16,
    parameter int         DIV_SLOW = 64,
    parameter logic [7:0] VEC_BASE = 8'h03,
    parameter logic [7:0] VEC_STEP = 8'h08
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] pin_i,
    input  logic [3:0] lvl_mode_i,
    input  logic [3:0] edge_mode_i,
    input  logic [1:0] flt_rate_i,
    input  logic [3:0] en_i,
    input  logic [3:0] clr_i,
    output logic [3:0] req_o,
    output logic       irq_o,
    output logic [7:0] vec_o,
    output logic [1:0] tmr_evt_o,
    output logic       wake_o
);

    logic [N_INT-1:0] req;
    logic [1:0]       evt;
    logic             flt3;

    for (genvar g = 0; g < 2; g++) begin : g_lvl
        extint_lvl_det u_det (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_i[g]),
            .mode_i (lvl_mode_e'(lvl_mode_i[2*g +: 2])),
            .clr_i  (clr_i[g]),
            .req_o  (req[g])
        );
    end

    extint_filter #(
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) u_flt (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i[3]),
        .rate_i (flt_rate_e'(flt_rate_i)),
        .lvl_o  (flt3)
    );

    for (genvar g = 0; g < 2; g++) begin : g_edge
        extint_edge_det u_det (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  ((g == 1) ? flt3 : pin_i[2]),
            .mode_i (edge_mode_e'(edge_mode_i[2*g +: 2])),
            .clr_i  (clr_i[2+g]),
            .req_o  (req[2+g]),
            .evt_o  (evt[g])
        );
    end

    extint_prio #(
        .N        (N_INT),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_prio (
        .clk   (clk),
        .rst   (rst),
        .act_i (req & en_i),
        .irq_o (irq_o),
        .vec_o (vec_o)
    );

    assign req_o     = req;
    assign tmr_evt_o = evt;
    assign wake_o    = |(req[1:0] & en_i[1:0]);

    a_r10_wake_implies_irq: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> irq_o);

    a_r9_int3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        tmr_evt_o[1] |=> !tmr_evt_o[1]);

    a_r6_masked_no_irq: assert property (@(posedge clk) disable iff (rst)
        (en_i == 4'h0) |-> (!irq_o && !wake_o));

endmodule

// File: tb/sim_extint_unit.sv
`timescale 1ns/1ps
module sim_extint_unit;

    localparam int F_REQ  = 0;
    localparam int F_IRQ  = 1;
    localparam int F_VEC  = 2;
    localparam int F_WAKE = 3;
    localparam int F_TMR  = 4;

    typedef struct {
        int         cyc;
        int         fld;
        logic [7:0] val;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin = '0;
    logic [3:0] lm  = '0;
    logic [3:0] em  = '0;
    logic [1:0] rate = '0;
    logic [3:0] en  = '0;
    logic [3:0] clr = '0;
    logic [3:0] req;
    logic       irq;
    logic [7:0] vec;
    logic [1:0] tmr;
    logic       wake;

    int    cyc    = 0;
    int    nchk   = 0;
    int    nfail  = 0;
    bit    done   = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    extint_unit u0 (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .lvl_mode_i  (lm),
        .edge_mode_i (em),
        .flt_rate_i  (rate),
        .en_i        (en),
        .clr_i       (clr),
        .req_o       (req),
        .irq_o       (irq),
        .vec_o       (vec),
        .tmr_evt_o   (tmr),
        .wake_o      (wake)
    );

    function automatic logic [7:0] actual(int fld);
        case (fld)
            F_REQ:  return {4'h0, req};
            F_IRQ:  return {7'h0, irq};
            F_VEC:  return vec;
            F_WAKE: return {7'h0, wake};
            default: return {6'h0, tmr};
        endcase
    endfunction

    task automatic expect_at(int dly, int fld, logic [7:0] v, string tag);
        item_t it;
        it.cyc = cyc + dly;
        it.fld = fld;
        it.val = v;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nfail, nchk);
    endtask

    // monitor: pops expectations for the current cycle and compares
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                item_t it;
                logic [7:0] a;
                it = sb.pop_front();
                a  = actual(it.fld);
                nchk++;
                if (it.cyc < cyc || a !== it.val) begin
                    nfail++;
                    $display("FAIL %s field=%0d actual=%h expected=%h", it.tag, it.fld, a, it.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        expect_at(1, F_REQ, 8'h0, "R1 reset req");
        expect_at(1, F_IRQ, 8'h0, "R1 reset irq");
        expect_at(1, F_VEC, 8'h0, "R1 reset vec");
        rst = 1'b0;
        expect_at(1, F_WAKE, 8'h0, "R1 reset wake");
        expect_at(1, F_TMR, 8'h0, "R1 reset tmr");
        @(negedge clk); en = 4'hF; lm = 4'h0; em = 4'h0;

        // R2 rising on pin 0
        @(negedge clk); pin[0] = 1'b1;
        expect_at(1, F_REQ, 8'h1, "R2 rise pin0 pending");
        expect_at(1, F_VEC, 8'h03, "R5 vector pin0");
        expect_at(1, F_WAKE, 8'h1, "R10 wake pin0");
        expect_at(1, F_IRQ, 8'h1, "R5 irq pin0");
        @(negedge clk); pin[0] = 1'b0;
        expect_at(1, F_REQ, 8'h1, "R2 held after fall");
        repeat (2) @(negedge clk);
        expect_at(1, F_REQ, 8'h1, "R2 still held");
        @(negedge clk); clr = 4'h1;
        expect_at(1, F_REQ, 8'h0, "R2 cleared");
        expect_at(1, F_IRQ, 8'h0, "R5 no irq");
        expect_at(1, F_VEC, 8'h0, "R5 idle vector");
        expect_at(1, F_WAKE, 8'h0, "R10 no wake");
        @(negedge clk); clr = 4'h0; lm[3:2] = 2'd1;

        // R2 falling on pin 1
        @(negedge clk); pin[1] = 1'b1;
        expect_at(1, F_REQ, 8'h0, "R2 rise ignored in falling mode");
        @(negedge clk); pin[1] = 1'b0;
        expect_at(1, F_REQ, 8'h2, "R2 fall pin1 pending");
        expect_at(1, F_VEC, 8'h0B, "R5 vector pin1");
        @(negedge clk); clr = 4'h2;
        expect_at(1, F_REQ, 8'h0, "R2 pin1 cleared");

        // R3 level modes on pin 0
        @(negedge clk); clr = 4'h0; lm[1:0] = 2'd2;
        expect_at(1, F_REQ, 8'h0, "R3 high-level pin low");
        @(negedge clk); pin[0] = 1'b1;
        expect_at(1, F_REQ, 8'h1, "R3 high-level active");
        expect_at(1, F_WAKE, 8'h1, "R10 wake on level");
        @(negedge clk); clr = 4'h1;
        expect_at(1, F_REQ, 8'h1, "R3 clear ignored");
        @(negedge clk); clr = 4'h0; pin[0] = 1'b0;
        expect_at(1, F_REQ, 8'h0, "R3 no latch");
        @(negedge clk); lm[1:0] = 2'd3;
        expect_at(1, F_REQ, 8'h1, "R3 low-level active");
        @(negedge clk); pin[0] = 1'b1;
        expect_at(1, F_REQ, 8'h0, "R3 low-level released");
        @(negedge clk); lm[1:0] = 2'd0;
        expect_at(1, F_REQ, 8'h0, "R2 mode switch no event");

        // R12 single-cycle pulse
        @(negedge clk); pin[0] = 1'b0;
        @(negedge clk); pin[0] = 1'b1;
        @(negedge clk); pin[0] = 1'b0;
        expect_at(1, F_REQ, 8'h1, "R12 one-cycle pulse");
        @(negedge clk); clr = 4'h1;
        expect_at(1, F_REQ, 8'h0, "R12 cleared");

        // R4 / R9 pin 2 both edges, disabled
        @(negedge clk); clr = 4'h0; em[1:0] = 2'd2; en = 4'hB;
        @(negedge clk); pin[2] = 1'b1;
        expect_at(1, F_REQ, 8'h4, "R4 both-edge rise");
        expect_at(1, F_IRQ, 8'h0, "R6 disabled no irq");
        expect_at(1, F_TMR, 8'h1, "R9 strobe while disabled");
        expect_at(2, F_TMR, 8'h0, "R9 strobe one cycle");
        @(negedge clk);
        @(negedge clk); en = 4'hF;
        expect_at(1, F_VEC, 8'h13, "R5 vector pin2");
        expect_at(1, F_WAKE, 8'h0, "R10 no wake from pin2");
        @(negedge clk); clr = 4'h4;
        @(negedge clk); clr = 4'h0; pin[2] = 1'b0;
        expect_at(1, F_REQ, 8'h4, "R4 both-edge fall");
        expect_at(1, F_TMR, 8'h1, "R9 strobe on fall");
        @(negedge clk); clr = 4'h4;
        @(negedge clk); clr = 4'h0; em[1:0] = 2'd1;
        @(negedge clk); pin[2] = 1'b1;
        expect_at(1, F_REQ, 8'h0, "R4 rise ignored in falling mode");
        expect_at(1, F_TMR, 8'h0, "R9 no strobe");
        @(negedge clk); pin[2] = 1'b0;
        expect_at(1, F_REQ, 8'h4, "R4 falling mode");
        @(negedge clk); clr = 4'h4;
        @(negedge clk); clr = 4'h0; em = 4'h0; rate = 2'd0;

        // R7 latency of pin 3, then priority stack
        @(negedge clk); pin[3] = 1'b1;
        expect_at(2, F_REQ, 8'h0, "R7 not yet accepted");
        expect_at(3, F_REQ, 8'h8, "R7 accepted after filter");
        expect_at(3, F_VEC, 8'h1B, "R5 vector pin3");
        expect_at(3, F_TMR, 8'h2, "R9 pin3 strobe");
        expect_at(4, F_TMR, 8'h0, "R9 pin3 strobe ends");
        repeat (4) @(negedge clk);
        pin[2] = 1'b1;
        expect_at(1, F_VEC, 8'h13, "R5 pin2 beats pin3");
        expect_at(1, F_REQ, 8'hC, "R4 two pending");
        @(negedge clk); pin[1] = 1'b1;
        @(negedge clk); pin[1] = 1'b0;
        expect_at(1, F_VEC, 8'h0B, "R5 pin1 beats pin2");
        expect_at(1, F_WAKE, 8'h1, "R10 wake pin1 edge");
        @(negedge clk); pin[0] = 1'b1;
        expect_at(1, F_VEC, 8'h03, "R5 pin0 beats all");
        expect_at(1, F_REQ, 8'hF, "R5 all pending");
        @(negedge clk); en = 4'hE;
        expect_at(1, F_VEC, 8'h0B, "R6 masked pin0 skipped");
        expect_at(1, F_REQ, 8'hF, "R6 pending kept");
        @(negedge clk); en = 4'h0;
        expect_at(1, F_IRQ, 8'h0, "R6 all masked irq");
        expect_at(1, F_VEC, 8'h00, "R6 all masked vec");
        expect_at(1, F_WAKE, 8'h0, "R6 all masked wake");
        @(negedge clk); en = 4'hF; clr = 4'hF;
        expect_at(1, F_REQ, 8'h0, "R2 all cleared");

        // R11 set beats clear
        @(negedge clk); clr = 4'h0; pin[0] = 1'b0;
        @(negedge clk); pin[0] = 1'b1; clr = 4'h1;
        expect_at(1, F_REQ, 8'h1, "R11 set beats clear");
        @(negedge clk);
        expect_at(1, F_REQ, 8'h0, "R11 later clear");
        @(negedge clk); clr = 4'h0; pin[3] = 1'b0;
        repeat (6) @(negedge clk);

        // R7 rate 0 pulse widths
        pin[3] = 1'b1;
        @(negedge clk); pin[3] = 1'b0;
        expect_at(3, F_REQ, 8'h0, "R7 one-cycle rejected");
        expect_at(3, F_TMR, 8'h0, "R7 no strobe");
        repeat (4) @(negedge clk);
        pin[3] = 1'b1;
        repeat (2) @(negedge clk);
        pin[3] = 1'b0;
        expect_at(1, F_REQ, 8'h8, "R7 two-cycle accepted");
        @(negedge clk); clr = 4'h8;
        @(negedge clk); clr = 4'h0;
        repeat (6) @(negedge clk);

        // R8 rate 1
        rate = 2'd1;
        @(negedge clk); pin[3] = 1'b1;
        repeat (16) @(negedge clk);
        pin[3] = 1'b0;
        repeat (40) @(negedge clk);
        expect_at(1, F_REQ, 8'h0, "R8 rate1 16 rejected");
        @(negedge clk); pin[3] = 1'b1;
        repeat (32) @(negedge clk);
        pin[3] = 1'b0;
        repeat (40) @(negedge clk);
        expect_at(1, F_REQ, 8'h8, "R8 rate1 32 accepted");
        @(negedge clk); clr = 4'h8;
        @(negedge clk); clr = 4'h0;

        // R8 rate 2
        rate = 2'd2;
        @(negedge clk); pin[3] = 1'b1;
        repeat (64) @(negedge clk);
        pin[3] = 1'b0;
        repeat (140) @(negedge clk);
        expect_at(1, F_REQ, 8'h0, "R8 rate2 64 rejected");
        @(negedge clk); pin[3] = 1'b1;
        repeat (128) @(negedge clk);
        pin[3] = 1'b0;
        repeat (140) @(negedge clk);
        expect_at(1, F_REQ, 8'h8, "R8 rate2 128 accepted");
        @(negedge clk); clr = 4'h8;
        expect_at(1, F_REQ, 8'h0, "R8 cleared");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule